// File: doc/BRIEF.md
# Low-Power Tick Generator

This block produces the single-cycle tick enable that paces the backup-domain low-power logic. Four 32 kHz-class sources each deliver a tick enable on the system clock. A 2-bit code picks one of them. When a deep-sleep entry is requested while a fast or primary source is picked, the block moves to the internal low-power RC source without software action, so the fast clocks can be stopped.

The picked tick stream can pass straight through, or it can be divided to about 1 kHz. The divider divides by 32 for a 32.768 kHz source or by 31.25 for a 32 kHz source. The 31.25 ratio comes from a repeating sequence of interval lengths. In counter mode a modifier can also stretch the rate by 1.024, which it does by suppressing a few ticks in every 128. A change of the effective source restarts all counting, so the output has a gap at a switch.

Top module: `lp_tick_gen`

## Requirements
- R1: The source code picks the tick input: 3 = internal low-power RC (`src_tick_i[3]`), 2 = secondary oscillator (`src_tick_i[2]`), 1 = primary oscillator (`src_tick_i[1]`), 0 = fast RC (`src_tick_i[0]`). Ticks on inputs that are not picked never reach the output.
- R2: While `ds_enter_i` is high and the code is 0 or 1, the effective source is input 3.
- R3: While `ds_enter_i` is high and the code is 2 or 3, the requested source stays in use.
- R4: With `div_en_i`=1 and `frac_div_i`=0, one output tick is issued for every 32 selected ticks, on the 32nd, 64th, and so on.
- R5: With `div_en_i`=1 and `frac_div_i`=1, the intervals repeat as 31, 31, 31, 32 selected ticks. Output ticks fall on the 31st, 62nd, 93rd and 125th tick of every 125.
- R6: With `div_en_i`=0 and the modifier off, every selected tick shows up on `tick_o` one clock cycle later.
- R7: With `cnt_mode_i`=1 and `mod_1024_i`=1, the modifier suppresses the 43rd, 86th and 128th of every 128 ticks that would otherwise reach the output. It counts from reset, from a source change, or from the moment it is enabled.
- R8: If `cnt_mode_i` or `mod_1024_i` is 0, no tick is suppressed.
- R9: When the effective source changes (including a deep-sleep fallback), the tick in that cycle is discarded and the divider and modifier restart from zero.
- R10: During reset and right after it, `tick_o` is 0.
- R11: `tick_o` is high only in the cycle after a tick from the effective source was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_tick_i | input | 4 | Tick enables of the four sources, indexed by source code |
| src_sel_i | input | 2 | Requested source code |
| ds_enter_i | input | 1 | Deep-sleep entry request |
| frac_div_i | input | 1 | 0: divide by 32, 1: divide by 31.25 |
| div_en_i | input | 1 | 1: divided tick out, 0: undivided tick out |
| cnt_mode_i | input | 1 | Counter mode active |
| mod_1024_i | input | 1 | Extra divide by 1.024 in counter mode |
| tick_o | output | 1 | Output tick enable, registered |

## Verification
The bench uses the default parameters: an integer ratio of 32, a short interval of 31 with every fourth interval long, and a modifier that drops 3 of every 128 ticks. These values keep one full fractional cycle (125 ticks) and a full modifier window (128 ticks) short. Each can therefore be run twice end to end, and every drop position and the long interval are hit exactly. The small ratios also make the restart after a source switch show up directly in where the first output tick lands.

// File: rtl/lp_tick_pkg.sv
package lp_tick_pkg;
  typedef enum logic [1:0] {
    SRC_FRC  = 2'b00,
    SRC_PRI  = 2'b01,
    SRC_SEC  = 2'b10,
    SRC_LPRC = 2'b11
  } src_e;
  localparam int unsigned NUM_SRC = 4;
endpackage

// File: rtl/lp_src_sel.sv
module lp_src_sel
  import lp_tick_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic [1:0]         src_sel_i,
  input  logic               ds_enter_i,
  output logic               tick_o,
  output logic               chg_o
);
  src_e eff_sel, sel_q;

  // fast sources are unsafe in deep sleep: fall back to low-power RC
  always_comb begin
    eff_sel = src_e'(src_sel_i);
    if (ds_enter_i && (eff_sel == SRC_FRC || eff_sel == SRC_PRI)) eff_sel = SRC_LPRC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= SRC_LPRC;
    else         sel_q <= eff_sel;
  end

  assign chg_o  = (eff_sel != sel_q);
  assign tick_o = src_tick_i[eff_sel] & ~chg_o;

  a_r2_ds_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_enter_i && !src_sel_i[1]) |=> (sel_q == SRC_LPRC));
  a_r3_ds_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_enter_i && src_sel_i[1]) |=> (sel_q == src_e'($past(src_sel_i))));
endmodule

// File: rtl/lp_frac_div.sv
module lp_frac_div #(
  parameter int unsigned INT_DIV    = 32,
  parameter int unsigned FRAC_SHORT = 31,
  parameter int unsigned LONG_EVERY = 4,
  localparam int unsigned CW = $clog2(INT_DIV + 1),
  localparam int unsigned PW = (LONG_EVERY > 1) ? $clog2(LONG_EVERY) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic frac_i,
  output logic tick_o
);
  localparam logic [CW-1:0] INT_LAST   = CW'(INT_DIV - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(FRAC_SHORT - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(FRAC_SHORT);
  localparam logic [PW-1:0] PH_LAST    = PW'(LONG_EVERY - 1);

  logic [CW-1:0] cnt_q, last;
  logic [PW-1:0] ph_q;
  logic          wrap;

  always_comb begin
    if (!frac_i)             last = INT_LAST;
    else if (ph_q == PH_LAST) last = LONG_LAST;
    else                     last = SHORT_LAST;
  end

  // >= keeps the counter bounded across a mode switch
  assign wrap   = tick_i && (cnt_q >= last);
  assign tick_o = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_q <= '0;
        if (frac_i) ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r4_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(INT_DIV));
  a_r9_div_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && ph_q == '0));
endmodule

// File: rtl/lp_rate_mod.sv
module lp_rate_mod #(
  parameter int unsigned DROP_NUM = 3,
  parameter int unsigned DROP_DEN = 128,
  localparam int unsigned AW = $clog2(DROP_DEN + DROP_NUM)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_i,
  output logic tick_o
);
  logic [AW-1:0] acc_q, nxt;
  logic          drop;

  assign nxt    = acc_q + AW'(DROP_NUM);
  assign drop   = en_i && tick_i && (nxt >= AW'(DROP_DEN));
  assign tick_o = tick_i && !drop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              acc_q <= '0;
    else if (clr_i || !en_i)  acc_q <= '0;
    else if (tick_i)          acc_q <= drop ? nxt - AW'(DROP_DEN) : nxt;
  end

  a_r7_acc_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < AW'(DROP_DEN));
endmodule

// File: rtl/lp_tick_gen.sv
module lp_tick_gen
  import lp_tick_pkg::*;
#(
  parameter int unsigned INT_DIV    = 32,
  parameter int unsigned FRAC_SHORT = 31,
  parameter int unsigned LONG_EVERY = 4,
  parameter int unsigned DROP_NUM   = 3,
  parameter int unsigned DROP_DEN   = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic [1:0]         src_sel_i,
  input  logic               ds_enter_i,
  input  logic               frac_div_i,
  input  logic               div_en_i,
  input  logic               cnt_mode_i,
  input  logic               mod_1024_i,
  output logic               tick_o
);
  logic sel_tick, chg, div_tick, pre_tick, mod_tick, mod_en, tick_q;

  assign mod_en = cnt_mode_i & mod_1024_i;

  lp_src_sel u_sel (
    .clk_i, .rst_ni, .src_tick_i, .src_sel_i, .ds_enter_i,
    .tick_o(sel_tick), .chg_o(chg)
  );

  lp_frac_div #(.INT_DIV(INT_DIV), .FRAC_SHORT(FRAC_SHORT), .LONG_EVERY(LONG_EVERY)) u_div (
    .clk_i, .rst_ni, .clr_i(chg), .tick_i(sel_tick), .frac_i(frac_div_i), .tick_o(div_tick)
  );

  assign pre_tick = div_en_i ? div_tick : sel_tick;

  lp_rate_mod #(.DROP_NUM(DROP_NUM), .DROP_DEN(DROP_DEN)) u_mod (
    .clk_i, .rst_ni, .clr_i(chg), .en_i(mod_en), .tick_i(pre_tick), .tick_o(mod_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= mod_tick;
  end
  assign tick_o = tick_q;

  a_r9_gap_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> !tick_o);
  a_r11_tick_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(sel_tick));
  a_r6_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div_en_i && !mod_en && sel_tick) |=> tick_o);
  a_r8_no_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mod_en && pre_tick) |=> tick_o);
endmodule

// File: tb/lp_tick_gen_tb_top.sv
module lp_tick_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_tick = '0;
  logic [1:0] src_sel = 2'b11;
  logic       ds_enter = 1'b0, frac_div = 1'b0, div_en = 1'b0;
  logic       cnt_mode = 1'b0, mod_1024 = 1'b0;
  logic       tick;
  int         checks = 0, fails = 0;

  always #10 clk = ~clk;

  lp_tick_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src_tick), .src_sel_i(src_sel),
    .ds_enter_i(ds_enter), .frac_div_i(frac_div), .div_en_i(div_en),
    .cnt_mode_i(cnt_mode), .mod_1024_i(mod_1024), .tick_o(tick)
  );

  // {sel[1:0], ds, ticks[3:0], expected}
  localparam logic [7:0] VEC [15] = '{
    8'b11_0_1000_1, 8'b11_0_0111_0, 8'b10_0_0100_1, 8'b10_0_1011_0,
    8'b01_0_0010_1, 8'b01_0_1101_0, 8'b00_0_0001_1, 8'b00_0_1110_0,
    8'b00_1_1000_1, 8'b00_1_0001_0, 8'b01_1_1000_1, 8'b01_1_0010_0,
    8'b10_1_0100_1, 8'b10_1_1000_0, 8'b11_1_1000_1
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs applied at negedge; tick_o sampled at the next negedge
  task automatic step(input logic [3:0] t, output logic o);
    src_tick = t;
    @(negedge clk);
    o = tick;
    src_tick = '0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic o;
    int   bad, outs, pos, per_idx, next_at;
    repeat (3) @(negedge clk);
    chk("R10 reset", int'(tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset", int'(tick), 0);

    // R1 R2 R3 R6 R11: undivided selection table
    foreach (VEC[i]) begin
      src_sel  = VEC[i][7:6];
      ds_enter = VEC[i][5];
      step(4'b0000, o);
      step(VEC[i][4:1], o);
      chk($sformatf("R1/R2/R3/R6/R11 vec%0d", i), int'(o), int'(VEC[i][0]));
    end
    ds_enter = 1'b0;

    // R9: tick in the change cycle is discarded
    src_sel = 2'b10;
    step(4'b0100, o);
    chk("R9 change discard", int'(o), 0);

    // R4: integer divide by 32
    src_sel = 2'b11; div_en = 1'b1; frac_div = 1'b0;
    step(4'b0000, o);
    bad = 0; outs = 0;
    for (int k = 1; k <= 96; k++) begin
      step(4'b1000, o);
      if (o) outs++;
      if (int'(o) != ((k % 32) == 0)) bad++;
    end
    chk("R4 misplaced ticks", bad, 0);
    chk("R4 count", outs, 3);

    // R5: fractional 31,31,31,32
    frac_div = 1'b1;
    bad = 0; outs = 0; per_idx = 0; next_at = 31;
    for (int k = 1; k <= 250; k++) begin
      step(4'b1000, o);
      if (o) outs++;
      if (k == next_at) begin
        if (!o) bad++;
        per_idx = (per_idx + 1) % 4;
        next_at += (per_idx == 3) ? 32 : 31;
      end else if (o) bad++;
    end
    chk("R5 misplaced ticks", bad, 0);
    chk("R5 count", outs, 8);

    // R9: restart of fractional phase on a source change
    for (int k = 1; k <= 40; k++) step(4'b1000, o);
    src_sel = 2'b10;
    step(4'b0100, o);
    chk("R9 change gap", int'(o), 0);
    bad = 0;
    for (int k = 1; k <= 31; k++) begin
      step(4'b0100, o);
      if (int'(o) != (k == 31)) bad++;
    end
    chk("R9 divider restarted", bad, 0);

    // R2 R9: deep-sleep fallback is a source change that restarts the divider
    src_sel = 2'b00; ds_enter = 1'b1;
    step(4'b1000, o);
    chk("R2/R9 fallback gap", int'(o), 0);
    outs = 0; bad = 0;
    for (int k = 1; k <= 31; k++) begin
      step(4'b1001, o);
      if (o) outs++;
      if (int'(o) != (k == 31)) bad++;
    end
    chk("R2 fallback divided", bad, 0);
    ds_enter = 1'b0; src_sel = 2'b11;
    step(4'b0000, o);

    // R7: drop 43rd, 86th, 128th of each 128
    div_en = 1'b0; cnt_mode = 1'b1; mod_1024 = 1'b1;
    src_sel = 2'b10;
    step(4'b0000, o);
    src_sel = 2'b11;
    step(4'b0000, o);
    bad = 0; outs = 0;
    for (int k = 1; k <= 256; k++) begin
      step(4'b1000, o);
      pos = k % 128;
      if (o) outs++;
      if (int'(o) != !(pos == 43 || pos == 86 || pos == 0)) bad++;
    end
    chk("R7 drop positions", bad, 0);
    chk("R7 count", outs, 250);

    // R8: modifier off when either bit is 0
    mod_1024 = 1'b0;
    outs = 0;
    for (int k = 1; k <= 128; k++) begin step(4'b1000, o); if (o) outs++; end
    chk("R8 mod bit 0", outs, 128);
    cnt_mode = 1'b0; mod_1024 = 1'b1;
    outs = 0;
    for (int k = 1; k <= 128; k++) begin step(4'b1000, o); if (o) outs++; end
    chk("R8 counter mode 0", outs, 128);

    // R7: modifier on top of the divided tick, counted from enable
    cnt_mode = 1'b1; div_en = 1'b1; frac_div = 1'b0;
    src_sel = 2'b10; step(4'b0000, o);
    outs = 0;
    for (int k = 1; k <= 43 * 32; k++) begin step(4'b0100, o); if (o) outs++; end
    chk("R7 divided 43rd dropped", outs, 42);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule